// File: doc/BRIEF.md
# Memory Protection Register Bank with Lock Arbitration

This block holds the programmable state of a physical memory protection unit: one 8-bit configuration byte and one address register per protection entry (16 entries by default), plus a small security-configuration register. A single-port request interface carries a register kind, an index and a data word. Writes pass through a layered lock policy before any state changes. Reads return the addressed register at once.

The complete configuration and address arrays and the three security bits are exported flat to a separate range and permission checker, which lives outside this block. A one-cycle change pulse tells that checker, or any cached decision logic, that an entry has been rewritten.

Enhanced mode is chosen by a strap input. When it is off, a set lock bit simply freezes its entry. When it is on, a bypass bit, a lockdown bit and a whitelist bit change which configuration writes are allowed. Two of these bits are sticky, and the bypass bit can only be armed while nothing is locked.

Top module: `prot_csr_bank`

## Requirements
- R1: After synchronous reset, every configuration byte, address register and security bit is zero, and the change pulse is low.
- R2: A configuration write (kind 0) at index k places byte i of the data word (bits 8i+7:8i) in entry 4k+i, for i below XLEN/8, and a configuration read reassembles the word the same way. Within a byte: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 power-of-two range), bit 7 lock. Bits 6:5 are kept as written.
- R3: With enhanced mode off, a byte aimed at an entry whose lock bit is set is dropped, while the other bytes of the same word are still written.
- R4: With enhanced mode on, a byte is accepted if the bypass bit is set, or if lockdown is clear and the entry is unlocked, or if lockdown is set and the new byte either has lock set with execute clear, or has lock clear with bits 2:0 not equal to 3'b110. Otherwise it is dropped.
- R5: An address write (kind 1) to an entry whose own lock bit is set is dropped.
- R6: An address write to entry n is dropped when entry n+1 is locked with match mode top-of-range. Entry n+1 locked in another mode does not block it.
- R7: In the security register (kind 2: bit 0 lockdown, bit 1 whitelist, bit 2 bypass), lockdown and whitelist cannot be cleared by a write once set.
- R8: The bypass bit cannot go from clear to set while any entry is locked. When no entry is locked, it can be set.
- R9: A configuration byte whose entry index is at or beyond the entry count, and an address access at such an index, is ignored on write and reads as zero.
- R10: The change pulse is high for exactly the cycle after an accepted configuration byte or address write. It stays low after reads, security writes and fully dropped writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | Enhanced lock policy enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 2 | 0 configuration, 1 address, 2 security |
| req_index | input | IDX_W | Register index |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Read data (combinational, zero when not reading) |
| cfg_flat | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| addr_flat | output | NUM_ENTRIES*XLEN | All address registers, entry e at slice e |
| sec_lockdown | output | 1 | Lockdown bit |
| sec_whitelist | output | 1 | Whitelist bit |
| sec_bypass | output | 1 | Rule-lock bypass bit |
| change_pulse | output | 1 | One-cycle pulse after an accepted entry write |

## Verification
The hardest states to reach are the enhanced-mode combinations. Lockdown is sticky and bypass can only be armed while nothing is locked, so any order of writes closes off states for good. The stimulus therefore resets a second time, turns on enhanced mode, and arms bypass before locking anything. It then locks entries under bypass, drops bypass, and only after that sets lockdown. This order lets every accept and reject case of the lockdown rules, including the write-plus-execute shared pattern on an unlocked entry, be reached in a single pass.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;

    typedef enum logic [1:0] {
        KIND_CFG  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_SEC  = 2'd2,
        KIND_RSVD = 2'd3
    } csr_kind_e;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } sec_bits_t;

    localparam int BIT_RD   = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_EX   = 2;
    localparam int BIT_LOCK = 7;

    function automatic logic cfg_locked(input logic [7:0] c);
        return c[BIT_LOCK];
    endfunction

    function automatic match_mode_e cfg_mode(input logic [7:0] c);
        return match_mode_e'(c[4:3]);
    endfunction

    function automatic logic cfg_blocks_prev(input logic [7:0] c);
        return cfg_locked(c) && (cfg_mode(c) == MATCH_TOR);
    endfunction

    function automatic logic cfg_byte_accept(input logic [7:0] cur,
                                             input logic [7:0] nxt,
                                             input logic       enh,
                                             input sec_bits_t  sec);
        logic ok;
        if (!enh) begin
            ok = !cfg_locked(cur);
        end else begin
            ok = sec.bypass || (!sec.lockdown && !cfg_locked(cur));
            if (sec.lockdown) begin
                if (nxt[BIT_LOCK] && !nxt[BIT_EX])
                    ok = 1'b1;
                if (!nxt[BIT_LOCK] && (nxt[2:0] != 3'b110))
                    ok = 1'b1;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/prot_cfg_gate.sv
module prot_cfg_gate
    import prot_csr_pkg::*;
(
    input  logic [7:0] cur_byte,
    input  logic [7:0] new_byte,
    input  logic       enh,
    input  sec_bits_t  sec,
    input  logic       in_range,
    input  logic       wr,
    output logic       accept
);
    always_comb begin
        accept = wr && in_range && cfg_byte_accept(cur_byte, new_byte, enh, sec);
    end
endmodule

// File: rtl/prot_sec_reg.sv
module prot_sec_reg
    import prot_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  sec_bits_t wdata,
    input  logic      any_locked,
    output sec_bits_t sec_q
);
    sec_bits_t sec_d;

    always_comb begin
        sec_d = sec_q;
        if (wr_en) begin
            sec_d.lockdown  = wdata.lockdown  | sec_q.lockdown;
            sec_d.whitelist = wdata.whitelist | sec_q.whitelist;
            sec_d.bypass    = wdata.bypass && (sec_q.bypass || !any_locked);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sec_q <= '0;
        else     sec_q <= sec_d;
    end

    AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        sec_q.lockdown |=> sec_q.lockdown);   // R7
    AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (rst)
        sec_q.whitelist |=> sec_q.whitelist); // R7
    AST_BYPASS_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (!sec_q.bypass && any_locked) |=> !sec_q.bypass); // R8
endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank
    import prot_csr_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enh_mode,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [1:0]                  req_kind,
    input  logic [IDX_W-1:0]            req_index,
    input  logic [XLEN-1:0]             req_wdata,
    output logic [XLEN-1:0]             rd_data,
    output logic [NUM_ENTRIES*8-1:0]    cfg_flat,
    output logic [NUM_ENTRIES*XLEN-1:0] addr_flat,
    output logic                        sec_lockdown,
    output logic                        sec_whitelist,
    output logic                        sec_bypass,
    output logic                        change_pulse
);
    localparam int BYTES   = XLEN / 8;
    localparam int ENTRY_W = $clog2(NUM_ENTRIES);
    localparam int TGT_W   = IDX_W + 3;

    logic [7:0]      cfg_q  [NUM_ENTRIES];
    logic [XLEN-1:0] addr_q [NUM_ENTRIES];
    sec_bits_t       sec_q;
    logic            chg_q;

    csr_kind_e kind;
    logic      cfg_wr, addr_wr, sec_wr, rd_en;

    always_comb begin
        kind    = csr_kind_e'(req_kind);
        cfg_wr  = req_valid && req_write && (kind == KIND_CFG);
        addr_wr = req_valid && req_write && (kind == KIND_ADDR);
        sec_wr  = req_valid && req_write && (kind == KIND_SEC);
        rd_en   = req_valid && !req_write;
    end

    // Per-byte configuration path
    logic [TGT_W-1:0] tgt      [BYTES];
    logic             tgt_in   [BYTES];
    logic [7:0]       cur_byte [BYTES];
    logic [BYTES-1:0] byte_acc;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        always_comb begin
            tgt[b]      = {req_index, 2'b00} + TGT_W'(b);
            tgt_in[b]   = tgt[b] < TGT_W'(NUM_ENTRIES);
            cur_byte[b] = tgt_in[b] ? cfg_q[tgt[b][ENTRY_W-1:0]] : 8'h00;
        end

        prot_cfg_gate u_gate (
            .cur_byte (cur_byte[b]),
            .new_byte (req_wdata[b*8 +: 8]),
            .enh      (enh_mode),
            .sec      (sec_q),
            .in_range (tgt_in[b]),
            .wr       (cfg_wr),
            .accept   (byte_acc[b])
        );
    end

    // Address path
    logic [ENTRY_W-1:0] a_ent;
    logic               a_in, own_lock, next_blk, addr_acc;

    always_comb begin
        a_ent    = req_index[ENTRY_W-1:0];
        a_in     = req_index < IDX_W'(NUM_ENTRIES);
        own_lock = cfg_locked(cfg_q[a_ent]);
        next_blk = 1'b0;
        for (int e = 0; e < NUM_ENTRIES - 1; e++) begin
            if (a_ent == ENTRY_W'(e))
                next_blk = cfg_blocks_prev(cfg_q[e+1]);
        end
        addr_acc = addr_wr && a_in && !own_lock && !next_blk;
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                cfg_q[e]  <= 8'h00;
                addr_q[e] <= '0;
            end
            chg_q <= 1'b0;
        end else begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (byte_acc[b] && (tgt[b] == TGT_W'(e)))
                        cfg_q[e] <= req_wdata[b*8 +: 8];
                end
                if (addr_acc && (a_ent == ENTRY_W'(e)))
                    addr_q[e] <= req_wdata;
            end
            chg_q <= (|byte_acc) || addr_acc;
        end
    end

    logic any_locked;
    always_comb begin
        any_locked = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++)
            any_locked = any_locked || cfg_locked(cfg_q[e]);
    end

    prot_sec_reg u_sec (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (sec_wr),
        .wdata      (sec_bits_t'(req_wdata[2:0])),
        .any_locked (any_locked),
        .sec_q      (sec_q)
    );

    // Read mux
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (kind)
                KIND_CFG: begin
                    for (int b = 0; b < BYTES; b++)
                        rd_data[b*8 +: 8] = cur_byte[b];
                end
                KIND_ADDR: rd_data = a_in ? addr_q[a_ent] : '0;
                KIND_SEC:  rd_data = XLEN'(sec_q);
                default:   rd_data = '0;
            endcase
        end
    end

    // Exports
    always_comb begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            cfg_flat[e*8 +: 8]       = cfg_q[e];
            addr_flat[e*XLEN +: XLEN] = addr_q[e];
        end
    end

    assign sec_lockdown  = sec_q.lockdown;
    assign sec_whitelist = sec_q.whitelist;
    assign sec_bypass    = sec_q.bypass;
    assign change_pulse  = chg_q;

    // Assertions
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
        AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!enh_mode && cfg_q[e][7]) |=> $stable(cfg_q[e]));  // R3
        AST_ADDR_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
            cfg_q[e][7] |=> $stable(addr_q[e]));                // R5
        if (e < NUM_ENTRIES - 1) begin : g_tor
            AST_ADDR_TOR_GUARD: assert property (@(posedge clk) disable iff (rst)
                (cfg_q[e+1][7] && cfg_q[e+1][4:3] == 2'b01) |=> $stable(addr_q[e])); // R6
        end
    end

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> $past(req_valid && req_write && req_kind != 2'd2)); // R10
endmodule

// File: tb/tb_prot_csr_bank.sv
module tb_prot_csr_bank;
    localparam int N  = 16;
    localparam int XL = 32;
    localparam int IW = 12;

    logic clk = 1'b0;
    logic rst, enh_mode, req_valid, req_write;
    logic [1:0]      req_kind;
    logic [IW-1:0]   req_index;
    logic [XL-1:0]   req_wdata, rd_data;
    logic [N*8-1:0]  cfg_flat;
    logic [N*XL-1:0] addr_flat;
    logic sec_lockdown, sec_whitelist, sec_bypass, change_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    prot_csr_bank #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) dut (
        .clk(clk), .rst(rst), .enh_mode(enh_mode),
        .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
        .req_index(req_index), .req_wdata(req_wdata), .rd_data(rd_data),
        .cfg_flat(cfg_flat), .addr_flat(addr_flat),
        .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
        .sec_bypass(sec_bypass), .change_pulse(change_pulse)
    );

    // Monitor: pops expected read values and compares
    always @(negedge clk) begin
        if (req_valid && !req_write && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: read got %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] k, input int idx, input logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_kind = k;
        req_index = IW'(idx); req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] k, input int idx, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_kind = k;
        req_index = IW'(idx); req_wdata = '0;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enh_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_kind = 2'd0; req_index = '0; req_wdata = '0;
        do_reset();

        // R1 reset state
        chk({31'b0, change_pulse}, 32'h0, "R1 pulse");
        chk(cfg_flat[31:0], 32'h0, "R1 cfg_flat");
        rd(2'd0, 0, 32'h0, "R1 cfg0");
        rd(2'd1, 5, 32'h0, "R1 addr5");
        rd(2'd2, 0, 32'h0, "R1 sec");

        // R2 packing
        wr(2'd0, 1, 32'h1B0A_0903);
        chk({31'b0, change_pulse}, 32'h1, "R10 pulse after cfg write");
        rd(2'd0, 1, 32'h1B0A_0903, "R2 cfg1 readback");
        chk({24'b0, cfg_flat[5*8 +: 8]}, 32'h09, "R2 entry5 byte");
        rd(2'd0, 0, 32'h0, "R2 cfg0 untouched");
        chk({31'b0, change_pulse}, 32'h0, "R10 no pulse on read");

        // R3 non-enhanced lock
        wr(2'd0, 0, 32'h0000_0089);
        wr(2'd0, 0, 32'h0707_0707);
        rd(2'd0, 0, 32'h0707_0789, "R3 locked byte kept");

        // R5 own lock
        wr(2'd1, 0, 32'h0000_1234);
        chk({31'b0, change_pulse}, 32'h0, "R10 no pulse on dropped write");
        rd(2'd1, 0, 32'h0, "R5 locked addr dropped");
        wr(2'd1, 1, 32'h0000_5555);
        rd(2'd1, 1, 32'h0000_5555, "R5 unlocked addr written");

        // R6 TOR guard
        wr(2'd0, 2, 32'h0000_8900);
        wr(2'd1, 8, 32'h0000_AAAA);
        rd(2'd1, 8, 32'h0, "R6 TOR next locked drops");
        wr(2'd0, 3, 32'h0000_0091);
        wr(2'd1, 11, 32'h0000_BEEF);
        rd(2'd1, 11, 32'h0000_BEEF, "R6 NA4 next locked allows");

        // R8 / R7 security register
        wr(2'd2, 0, 32'h4);
        rd(2'd2, 0, 32'h0, "R8 bypass blocked while locked");
        wr(2'd2, 0, 32'h3);
        rd(2'd2, 0, 32'h3, "R7 set lockdown whitelist");
        wr(2'd2, 0, 32'h0);
        rd(2'd2, 0, 32'h3, "R7 sticky");
        chk({29'b0, sec_bypass, sec_whitelist, sec_lockdown}, 32'h3, "R7 sec ports");

        // Enhanced mode
        do_reset();
        enh_mode = 1'b1;
        rd(2'd2, 0, 32'h0, "R1 sec after second reset");
        wr(2'd2, 0, 32'h4);
        rd(2'd2, 0, 32'h4, "R8 bypass arm when unlocked");
        wr(2'd0, 0, 32'h0000_0085);
        wr(2'd0, 0, 32'h0000_0001);
        rd(2'd0, 0, 32'h0000_0001, "R4 bypass overrides lock");
        wr(2'd2, 0, 32'h0);
        rd(2'd2, 0, 32'h0, "R8 bypass cleared");
        wr(2'd0, 0, 32'h0000_0085);
        wr(2'd0, 0, 32'h0000_0000);
        rd(2'd0, 0, 32'h0000_0085, "R4 locked without lockdown dropped");
        wr(2'd2, 0, 32'h4);
        rd(2'd2, 0, 32'h0, "R8 rearm refused");
        wr(2'd2, 0, 32'h1);
        rd(2'd2, 0, 32'h1, "R7 lockdown set");
        wr(2'd0, 0, 32'h0000_0081);
        rd(2'd0, 0, 32'h0000_0081, "R4 lockdown lock no exec accepted");
        wr(2'd0, 0, 32'h0000_0084);
        rd(2'd0, 0, 32'h0000_0081, "R4 lockdown lock exec dropped");
        wr(2'd0, 0, 32'h0000_0003);
        rd(2'd0, 0, 32'h0000_0003, "R4 lockdown unlocked rw accepted");
        wr(2'd0, 0, 32'h0000_0006);
        rd(2'd0, 0, 32'h0000_0003, "R4 lockdown wx pattern dropped");

        // R9 out of range
        wr(2'd0, 4, 32'hFFFF_FFFF);
        chk({31'b0, change_pulse}, 32'h0, "R9 no pulse out of range cfg");
        rd(2'd0, 4, 32'h0, "R9 cfg out of range reads zero");
        wr(2'd1, 16, 32'h1111_1111);
        chk({31'b0, change_pulse}, 32'h0, "R9 no pulse out of range addr");
        rd(2'd1, 16, 32'h0, "R9 addr out of range reads zero");
        rd(2'd0, 3, 32'h0, "R9 last entries untouched");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule